// File: doc/BRIEF.md
# Battery Backup Rail Source Selector

This block decides whether a backed-up output rail is fed from the main supply or from a backup battery. Three analog comparators outside the block supply the inputs as asynchronous digital flags. The first says the main supply is above its undervoltage trip level. The second says the main supply is above the battery voltage plus a small margin. The third says the main supply is below the battery voltage minus that same margin. The block brings each flag into its clock domain and applies the selection rules. A new source takes effect only after the condition that calls for it has held for a programmable number of clock ticks.

While the main supply is healthy, the undervoltage flag alone keeps the rail on the main supply. Below the trip level, the battery comparison decides. The two margins form a hysteresis band, and inside that band the previous choice is kept. The outputs are a source select, a battery-on line for an external pass transistor, and a backup-mode flag that tells the serial interface to refuse traffic. The block also flags the impossible case where both margin comparators report at once. That error flag stays set until reset.

Top module: `bsw_top`

## Requirements
- R1: While the synchronised main-above-trip flag is high, the selection goes to, or stays at, the main supply, whatever the two margin flags say.
- R2: With main-above-trip low, margin-above high and margin-below low, the main supply is selected.
- R3: With main-above-trip low, margin-below high and margin-above low, the battery is selected.
- R4: With main-above-trip low and both margin flags low (inside the hysteresis band), the current selection is kept.
- R5: `src_sel` encodes the source as 0 for main and 1 for battery. `batt_on` is high exactly while the battery is selected.
- R6: `backup_mode` is high exactly while the battery is selected, and it forbids serial communication.
- R7: Each flag passes through a two-stage synchroniser. A selection change is committed only after the new target has held for `HOLD_TICKS` consecutive cycles. A flag change applied before clock edge 1 therefore shows on the outputs after edge `HOLD_TICKS`+2, and not after edge `HOLD_TICKS`+1. A condition lasting fewer than `HOLD_TICKS` cycles causes no change.
- R8: When both margin flags are high at once, `flag_err` rises after the third clock edge and stays high until reset. With main-above-trip low, the selection is held during that time.
- R9: After reset, the main supply is selected and `batt_on`, `backup_mode` and `flag_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one tick of the commit filter per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_main_ok | input | 1 | Asynchronous flag: main supply above undervoltage trip |
| cmp_main_hi | input | 1 | Asynchronous flag: main supply above battery plus margin |
| cmp_main_lo | input | 1 | Asynchronous flag: main supply below battery minus margin |
| src_sel | output | 1 | Selected rail source, 0 main, 1 battery |
| batt_on | output | 1 | High while the battery feeds the rail |
| backup_mode | output | 1 | High in backup mode; serial traffic not allowed |
| flag_err | output | 1 | Sticky flag: both margin comparators seen high together |

## Verification
The bench ramps the supply down through the band and then below the battery, and brings it back up. It checks that the band holds whichever source was last chosen; a design without hysteresis would drop back to main, or fail to leave battery, as soon as the flags cleared. Noise pulses one tick shorter than the commit window must leave the rail alone, and pulses exactly as long must switch it. This catches an off-by-one filter, or a missing one that would chatter. The bench also checks the exact commit edge, the priority of the trip flag over a battery-favouring comparison, and the illegal flag pair. On that pair, a wrong design would switch source or lose the sticky error before reset.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_BATT = 1'b1
  } src_e;

  typedef struct packed {
    logic main_ok;
    logic main_hi;
    logic main_lo;
  } cmp_flags_t;

  localparam int unsigned FLAG_W = $bits(cmp_flags_t);

  function automatic logic flags_illegal(cmp_flags_t f);
    return f.main_hi & f.main_lo;
  endfunction

  // Selection rule: trip flag wins, illegal pair and band hold, else margins decide.
  function automatic src_e pick_source(cmp_flags_t f, src_e cur);
    src_e nxt;
    if (f.main_ok)             nxt = SRC_MAIN;
    else if (flags_illegal(f)) nxt = cur;
    else if (f.main_hi)        nxt = SRC_MAIN;
    else if (f.main_lo)        nxt = SRC_BATT;
    else                       nxt = cur;
    return nxt;
  endfunction

endpackage

// File: rtl/bsw_sync.sv
module bsw_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[LAST];
  end

endmodule

// File: rtl/bsw_decide.sv
module bsw_decide
  import bsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cmp_flags_t flags,
  input  src_e       cur_src,
  output src_e       target_src,
  output logic       illegal_now,
  output logic       err_sticky
);

  assign target_src  = pick_source(flags, cur_src);
  assign illegal_now = flags_illegal(flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           err_sticky <= 1'b0;
    else if (illegal_now) err_sticky <= 1'b1;
  end

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  p_err_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_now |=> err_sticky);

  p_trip_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flags.main_ok |-> (target_src == SRC_MAIN));

endmodule

// File: rtl/bsw_commit.sv
module bsw_commit
  import bsw_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e target_src,
  output src_e cur_src,
  output logic commit_ev
);

  localparam int unsigned CNT_W   = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam int unsigned CNT_MAX = HOLD_TICKS - 1;

  logic [CNT_W-1:0] cnt_q;
  logic             differ;
  logic             at_limit;

  assign differ    = (target_src != cur_src);
  assign at_limit  = (cnt_q == CNT_W'(CNT_MAX));
  assign commit_ev = differ & at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cur_src <= SRC_MAIN;
    end else if (!differ) begin
      cnt_q   <= '0;
    end else if (at_limit) begin
      cnt_q   <= '0;
      cur_src <= target_src;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  p_commit_after_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_src) |-> $past(cnt_q) == CNT_W'(CNT_MAX));

  p_count_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX));

endmodule

// File: rtl/bsw_top.sv
module bsw_top
  import bsw_pkg::*;
#(
  parameter int unsigned HOLD_TICKS  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_main_ok,
  input  logic cmp_main_hi,
  input  logic cmp_main_lo,
  output logic src_sel,
  output logic batt_on,
  output logic backup_mode,
  output logic flag_err
);

  cmp_flags_t flags_raw;
  cmp_flags_t flags_s;
  logic [FLAG_W-1:0] flags_s_vec;
  src_e target_src;
  src_e cur_src;
  logic illegal_now;
  logic commit_ev;

  assign flags_raw = '{main_ok: cmp_main_ok, main_hi: cmp_main_hi, main_lo: cmp_main_lo};

  bsw_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (flags_raw),
    .q_sync  (flags_s_vec)
  );
  assign flags_s = cmp_flags_t'(flags_s_vec);

  bsw_decide u_decide (
    .clk         (clk),
    .rst_n       (rst_n),
    .flags       (flags_s),
    .cur_src     (cur_src),
    .target_src  (target_src),
    .illegal_now (illegal_now),
    .err_sticky  (flag_err)
  );

  bsw_commit #(.HOLD_TICKS(HOLD_TICKS)) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .target_src (target_src),
    .cur_src    (cur_src),
    .commit_ev  (commit_ev)
  );

  assign src_sel     = cur_src;
  assign batt_on     = (cur_src == SRC_BATT);
  assign backup_mode = (cur_src == SRC_BATT);

  p_to_batt_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_sel) |-> $past(!flags_s.main_ok && flags_s.main_lo && !flags_s.main_hi));

  p_to_main_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(src_sel) |-> $past(flags_s.main_ok || (flags_s.main_hi && !flags_s.main_lo)));

  p_band_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_s.main_ok && !flags_s.main_hi && !flags_s.main_lo) |=> $stable(src_sel));

  p_illegal_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_s.main_ok && illegal_now) |=> $stable(src_sel));

  p_change_needs_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_sel) |-> $past(commit_ev));

endmodule

// File: tb/test_bsw_top.sv
module test_bsw_top;

  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned HOLD       = 4;
  localparam int unsigned SETTLE     = HOLD + 6;
  localparam int unsigned WD_CYCLES  = 20000;

  typedef struct {
    logic  exp_batt;
    logic  exp_err;
    string req;
  } exp_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_main_ok = 1'b1;
  logic cmp_main_hi = 1'b1;
  logic cmp_main_lo = 1'b0;
  logic src_sel, batt_on, backup_mode, flag_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  exp_item_t sb_q[$];
  event chk_ev;

  logic model_batt = 1'b0;
  logic model_err = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bsw_top #(.HOLD_TICKS(HOLD)) i_bsw_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_main_ok (cmp_main_ok),
    .cmp_main_hi (cmp_main_hi),
    .cmp_main_lo (cmp_main_lo),
    .src_sel     (src_sel),
    .batt_on     (batt_on),
    .backup_mode (backup_mode),
    .flag_err    (flag_err)
  );

  task automatic cmp1(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares them with the ports.
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_item_t it;
        it = sb_q.pop_front();
        cmp1(it.req, "src_sel",     src_sel,     it.exp_batt);
        cmp1(it.req, "batt_on",     batt_on,     it.exp_batt);
        cmp1(it.req, "backup_mode", backup_mode, it.exp_batt);
        cmp1(it.req, "flag_err",    flag_err,    it.exp_err);
      end
    end
  end

  task automatic expect_now(logic b, logic e, string req);
    exp_item_t it;
    it.exp_batt = b;
    it.exp_err  = e;
    it.req      = req;
    sb_q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic drive(logic ok, logic hi, logic lo);
    @(negedge clk);
    cmp_main_ok = ok;
    cmp_main_hi = hi;
    cmp_main_lo = lo;
  endtask

  // Independent model of the selection rules.
  task automatic model_step(logic ok, logic hi, logic lo);
    if (hi && lo) model_err = 1'b1;
    if (ok)              model_batt = 1'b0;
    else if (hi && lo)   model_batt = model_batt;
    else if (hi)         model_batt = 1'b0;
    else if (lo)         model_batt = 1'b1;
  endtask

  task automatic apply(logic ok, logic hi, logic lo, string req);
    drive(ok, hi, lo);
    model_step(ok, hi, lo);
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
    expect_now(model_batt, model_err, req);
  endtask

  task automatic pulse_lo(int len);
    drive(1'b0, 1'b0, 1'b1);
    repeat (len - 1) @(negedge clk);
    drive(1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_batt = 1'b0;
    model_err  = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9: reset state
    expect_now(1'b0, 1'b0, "R9 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_now(1'b0, 1'b0, "R9 after reset");

    // R1: trip flag high overrides a battery-favouring comparison
    apply(1'b1, 1'b0, 1'b1, "R1 ok with lo");
    apply(1'b1, 1'b1, 1'b0, "R1 ok with hi");

    // Slow ramp down: into band, then below battery
    apply(1'b0, 1'b1, 1'b0, "R2 below trip above batt");
    apply(1'b0, 1'b0, 1'b0, "R4 band keeps main");
    apply(1'b0, 1'b0, 1'b1, "R3 below batt selects battery");
    // R5/R6 covered by the three output comparisons of each item
    apply(1'b0, 1'b0, 1'b0, "R4 band keeps battery");
    apply(1'b1, 1'b0, 1'b1, "R1 trip recovery forces main");
    apply(1'b0, 1'b0, 1'b0, "R4 band keeps main again");

    // R7: noise pulses around the switch point
    pulse_lo(HOLD - 1);
    repeat (SETTLE) @(negedge clk);
    expect_now(1'b0, 1'b0, "R7 short pulse ignored");
    pulse_lo(HOLD);
    repeat (SETTLE) @(negedge clk);
    model_batt = 1'b1;
    expect_now(1'b1, 1'b0, "R7 full pulse commits, R4 band holds");
    for (int k = 0; k < 6; k++) begin
      drive(1'b0, 1'b1, 1'b0);
      drive(1'b0, 1'b0, 1'b0);
    end
    repeat (SETTLE) @(negedge clk);
    expect_now(1'b1, 1'b0, "R7 chatter ignored");

    // R7: exact commit edge
    drive(1'b0, 1'b1, 1'b0);
    repeat (HOLD + 1) @(posedge clk);
    @(negedge clk);
    expect_now(1'b1, 1'b0, "R7 not yet at edge HOLD+1");
    @(posedge clk);
    @(negedge clk);
    expect_now(1'b0, 1'b0, "R7 switched at edge HOLD+2");
    model_batt = 1'b0;

    // R8: illegal pair holds selection and sets sticky error
    apply(1'b0, 1'b0, 1'b1, "R3 back to battery");
    drive(1'b0, 1'b1, 1'b1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    cmp1("R8", "flag_err before edge 3", flag_err, 1'b0);
    @(posedge clk);
    @(negedge clk);
    cmp1("R8", "flag_err after edge 3", flag_err, 1'b1);
    model_err = 1'b1;
    repeat (SETTLE) @(negedge clk);
    expect_now(1'b1, 1'b1, "R8 illegal holds battery");
    apply(1'b0, 1'b1, 1'b0, "R8 error stays sticky, R2 main");
    apply(1'b0, 1'b0, 1'b0, "R8 sticky in band");

    // R9: reset clears error and selection
    do_reset();
    @(negedge clk);
    expect_now(1'b0, 1'b0, "R9 reset clears sticky error");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule